// File: doc/BRIEF.md
# Segment-Table Bus Address Decoder

This block sits between a 16-bit bus master with a 24-bit byte address and the memories and byte-wide peripherals behind it. For every qualified access it resolves a single device select, a peripheral register index and masked RAM and ROM word offsets. It also supplies the read data for the cases the decoder answers itself: unassigned space, peripheral reads with a forced upper byte, and reads of a small phase counter.

Decoding uses a 32-entry table indexed by address bits [23:19], so each entry covers 512 KB. Two table layouts exist for the lower 8 MB. The boot layout mirrors ROM from address zero. The run layout places RAM at zero. A registered overlay flag picks the layout. The flag comes out of reset set and is loaded through a write enable. Word accesses to either serial-controller window step a wrapping phase counter, and that counter can be read back through its own window.

Top module: `bus_addr_decoder`

## Requirements
- R1: With the overlay flag set, the lower 8 MB decodes in 1 MB steps as ROM, unassigned, ROM, unassigned, ROM, unassigned, and 0x600000-0x7FFFFF decodes as RAM. The table index is addr_i[23:19].
- R2: With the overlay flag clear, 0x000000-0x3FFFFF decodes as RAM, 0x400000-0x4FFFFF as ROM and 0x500000-0x7FFFFF as unassigned.
- R3: At and above 0x800000 the map does not depend on the overlay flag. The windows are: 0x900000-0x9FFFFF serial read/reset, 0xB00000-0xBFFFFF serial write, 0xD00000-0xDFFFFF floppy controller, 0xE80000-0xEFFFFF VIA, 0xF00000-0xF7FFFF phase read. Every other range there is unassigned.
- R4: sel_o bit positions are: 0 RAM, 1 ROM, 2 VIA, 3 floppy, 4 serial read, 5 serial reset, 6 serial write. At most one bit is ever set. A read of unassigned space sets no select, sets rdata_drive_o and returns 0xFFFF. A write there sets no select and no drive.
- R5: A RAM access of either direction sets sel_o[0]. A ROM read sets sel_o[1]. A ROM write sets no select. For RAM and ROM the decoder does not drive read data, so rdata_drive_o is 0 and rdata_o is 0x0000. Whenever rdata_drive_o is 0, rdata_o is 0x0000.
- R6: The VIA is selected only when addr_i[0] is 0, and the floppy controller only when addr_i[0] is 1. The other lane behaves as unassigned. A read from either device returns {0xFF, device byte}.
- R7: In the serial read/reset window, a word access steps the phase counter, sets no select, and a read returns 0xFFFF. A byte access with A0=1 sets sel_o[5], and a read returns 0xFFFF. A byte access with A0=0 sets sel_o[4], and a read returns {0xFF, serial byte}.
- R8: In the serial write window, a word access steps the phase counter, sets no select, and a read returns 0xFFFF. A byte access with A0=1 sets sel_o[6], and a read returns 0xFFFF. A byte access with A0=0 behaves as unassigned.
- R9: A read in the phase window returns {0xFF, 5'b0, phase[2:0]} and sets no select. A write there has no effect.
- R10: phase_o resets to 0. It increments by one on the clock edge that ends each qualified word access to a serial window, and it wraps at its width.
- R11: The overlay flag resets to 1. It takes overlay_i on a clock edge where overlay_we_i is high, and the new layout applies from the next cycle.
- R12: reg_idx_o equals addr_i[12:9]. ram_off_o equals addr_i[23:1] masked by RAM_WORDS-1, and rom_off_o equals addr_i[23:1] masked by ROM_WORDS-1.
- R13: With valid_i low, no select is set, rdata_drive_o is 0 and the phase counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access qualifier (data strobe active) |
| addr_i | input | 24 | Byte address |
| rd_i | input | 1 | 1 = read, 0 = write |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| overlay_we_i | input | 1 | Load enable for the overlay flag |
| overlay_i | input | 1 | New overlay flag value |
| via_rdata_i | input | 8 | VIA read byte |
| fdc_rdata_i | input | 8 | Floppy controller read byte |
| scc_rdata_i | input | 8 | Serial controller read byte |
| sel_o | output | 7 | One-hot device selects |
| reg_idx_o | output | 4 | Peripheral register index |
| ram_off_o | output | RAM_OFF_W | RAM word offset |
| rom_off_o | output | ROM_OFF_W | ROM word offset |
| rdata_o | output | 16 | Decoder-supplied read data |
| rdata_drive_o | output | 1 | rdata_o is valid for this read |
| phase_o | output | PHASE_W | Phase counter |

## Verification
A full sweep visits every one of the 32 segments under both overlay settings. Each visit tries all eight combinations of direction, size and A0. This exposes any wrong table entry and any layout leaking above 8 MB, and it separates the per-lane and per-size behaviour of the VIA, floppy and serial windows. A run of consecutive word accesses to the serial windows, read back through the phase window, confirms the stepping, the wrap at the counter width and the one-cycle latency. Accesses with random middle address bits and idle cycles with valid_i low check the register index, the offset masking and the absence of side effects.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

  typedef enum logic [2:0] {
    DEV_NONE  = 3'd0,
    DEV_RAM   = 3'd1,
    DEV_ROM   = 3'd2,
    DEV_VIA   = 3'd3,
    DEV_FDC   = 3'd4,
    DEV_SCCRD = 3'd5,
    DEV_SCCWR = 3'd6,
    DEV_PHASE = 3'd7
  } dev_e;

  localparam int unsigned SEL_RAM   = 0;
  localparam int unsigned SEL_ROM   = 1;
  localparam int unsigned SEL_VIA   = 2;
  localparam int unsigned SEL_FDC   = 3;
  localparam int unsigned SEL_SCCRD = 4;
  localparam int unsigned SEL_SCCRS = 5;
  localparam int unsigned SEL_SCCWR = 6;
  localparam int unsigned SEL_W     = 7;

  localparam int unsigned ADDR_W = 24;
  localparam int unsigned SEG_W  = 5;

  // Table entry for one 512 KB segment; ov picks the boot layout for the low 8 MB.
  function automatic dev_e seg_device(input logic [SEG_W-1:0] seg, input logic ov);
    dev_e d;
    if (seg < 5'd16) begin
      if (ov) begin
        if (seg >= 5'd12)   d = DEV_RAM;
        else if (seg[1])    d = DEV_NONE;
        else                d = DEV_ROM;
      end else begin
        if (seg < 5'd8)       d = DEV_RAM;
        else if (seg < 5'd10) d = DEV_ROM;
        else                  d = DEV_NONE;
      end
    end else begin
      case (seg)
        5'd18, 5'd19: d = DEV_SCCRD;
        5'd22, 5'd23: d = DEV_SCCWR;
        5'd26, 5'd27: d = DEV_FDC;
        5'd29:        d = DEV_VIA;
        5'd30:        d = DEV_PHASE;
        default:      d = DEV_NONE;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/seg_map.sv
module seg_map
  import addr_dec_pkg::*;
#(
  parameter int unsigned SW = SEG_W
) (
  input  logic [SW-1:0] seg_i,
  input  logic          overlay_i,
  output dev_e          dev_o
);
  localparam int unsigned NUM_SEG = 1 << SW;

  dev_e tbl_boot [NUM_SEG];
  dev_e tbl_run  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign tbl_boot[g] = seg_device(SEG_W'(g), 1'b1);
    assign tbl_run[g]  = seg_device(SEG_W'(g), 1'b0);
  end

  assign dev_o = overlay_i ? tbl_boot[seg_i] : tbl_run[seg_i];
endmodule

// File: rtl/access_resolve.sv
module access_resolve
  import addr_dec_pkg::*;
(
  input  logic             valid_i,
  input  logic             rd_i,
  input  logic             word_i,
  input  logic             a0_i,
  input  dev_e             dev_i,
  input  logic [7:0]       via_rdata_i,
  input  logic [7:0]       fdc_rdata_i,
  input  logic [7:0]       scc_rdata_i,
  input  logic [2:0]       phase_lo_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [15:0]      rdata_o,
  output logic             drive_o,
  output logic             step_o
);
  logic unmapped;

  always_comb begin
    sel_o    = '0;
    rdata_o  = '0;
    drive_o  = 1'b0;
    step_o   = 1'b0;
    unmapped = 1'b0;
    if (valid_i) begin
      unique case (dev_i)
        DEV_RAM: sel_o[SEL_RAM] = 1'b1;
        DEV_ROM: sel_o[SEL_ROM] = rd_i;
        DEV_VIA: begin
          if (!a0_i) begin
            sel_o[SEL_VIA] = 1'b1;
            if (rd_i) begin
              drive_o = 1'b1;
              rdata_o = {8'hFF, via_rdata_i};
            end
          end else unmapped = 1'b1;
        end
        DEV_FDC: begin
          if (a0_i) begin
            sel_o[SEL_FDC] = 1'b1;
            if (rd_i) begin
              drive_o = 1'b1;
              rdata_o = {8'hFF, fdc_rdata_i};
            end
          end else unmapped = 1'b1;
        end
        DEV_SCCRD: begin
          if (word_i) begin
            step_o   = 1'b1;
            unmapped = 1'b1;
          end else if (a0_i) begin
            sel_o[SEL_SCCRS] = 1'b1;
            unmapped         = 1'b1;   // reads back all ones
          end else begin
            sel_o[SEL_SCCRD] = 1'b1;
            if (rd_i) begin
              drive_o = 1'b1;
              rdata_o = {8'hFF, scc_rdata_i};
            end
          end
        end
        DEV_SCCWR: begin
          if (word_i) begin
            step_o   = 1'b1;
            unmapped = 1'b1;
          end else begin
            sel_o[SEL_SCCWR] = a0_i;
            unmapped         = 1'b1;
          end
        end
        DEV_PHASE: begin
          if (rd_i) begin
            drive_o = 1'b1;
            rdata_o = {8'hFF, 5'b0, phase_lo_i};
          end
        end
        default: unmapped = 1'b1;
      endcase
      if (unmapped && rd_i) begin
        drive_o = 1'b1;
        rdata_o = 16'hFFFF;
      end
    end
  end
endmodule

// File: rtl/phase_ctr.sv
module phase_ctr #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int unsigned RAM_WORDS = 262144,
  parameter int unsigned ROM_WORDS = 65536,
  parameter int unsigned PHASE_W   = 3,
  localparam int unsigned RAM_OFF_W = $clog2(RAM_WORDS),
  localparam int unsigned ROM_OFF_W = $clog2(ROM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 word_i,
  input  logic                 overlay_we_i,
  input  logic                 overlay_i,
  input  logic [7:0]           via_rdata_i,
  input  logic [7:0]           fdc_rdata_i,
  input  logic [7:0]           scc_rdata_i,
  output logic [SEL_W-1:0]     sel_o,
  output logic [3:0]           reg_idx_o,
  output logic [RAM_OFF_W-1:0] ram_off_o,
  output logic [ROM_OFF_W-1:0] rom_off_o,
  output logic [15:0]          rdata_o,
  output logic                 rdata_drive_o,
  output logic [PHASE_W-1:0]   phase_o
);
  localparam logic [ADDR_W-2:0] RAM_MASK = (ADDR_W-1)'(RAM_WORDS - 1);
  localparam logic [ADDR_W-2:0] ROM_MASK = (ADDR_W-1)'(ROM_WORDS - 1);

  logic overlay_q;
  dev_e dev;
  logic step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           overlay_q <= 1'b1;
    else if (overlay_we_i) overlay_q <= overlay_i;
  end

  seg_map #(.SW(SEG_W)) u_seg_map (
    .seg_i     (addr_i[ADDR_W-1 -: SEG_W]),
    .overlay_i (overlay_q),
    .dev_o     (dev)
  );

  access_resolve u_resolve (
    .valid_i     (valid_i),
    .rd_i        (rd_i),
    .word_i      (word_i),
    .a0_i        (addr_i[0]),
    .dev_i       (dev),
    .via_rdata_i (via_rdata_i),
    .fdc_rdata_i (fdc_rdata_i),
    .scc_rdata_i (scc_rdata_i),
    .phase_lo_i  (phase_o[2:0]),
    .sel_o       (sel_o),
    .rdata_o     (rdata_o),
    .drive_o     (rdata_drive_o),
    .step_o      (step)
  );

  phase_ctr #(.W(PHASE_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .cnt_o  (phase_o)
  );

  logic [ADDR_W-2:0] word_addr;
  logic [ADDR_W-2:0] ram_full, rom_full;
  assign word_addr = addr_i[ADDR_W-1:1];
  assign ram_full  = word_addr & RAM_MASK;
  assign rom_full  = word_addr & ROM_MASK;
  assign ram_off_o = ram_full[RAM_OFF_W-1:0];
  assign rom_off_o = rom_full[ROM_OFF_W-1:0];
  assign reg_idx_o = addr_i[12:9];
endmodule

// File: rtl/bus_addr_decoder_chk.sv
module bus_addr_decoder_chk
  import addr_dec_pkg::*;
#(
  parameter int unsigned PHASE_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                rd_i,
  input logic                word_i,
  input logic [SEL_W-1:0]    sel_o,
  input logic [15:0]         rdata_o,
  input logic                rdata_drive_o,
  input logic [PHASE_W-1:0]  phase_o
);
  logic scc_word;
  assign scc_word = valid_i && word_i &&
                    (addr_i[23:20] == 4'h9 || addr_i[23:20] == 4'hB);

  // R4
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R4
  unassigned_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_i && addr_i[23:19] == 5'd31) |-> (rdata_drive_o && rdata_o == 16'hFFFF && sel_o == '0));

  // R5
  rom_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rd_i) |-> !sel_o[SEL_ROM]);

  // R5
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_drive_o |-> rdata_o == 16'h0000);

  // R6
  via_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[SEL_VIA] |-> !addr_i[0]);

  // R6
  fdc_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[SEL_FDC] |-> addr_i[0]);

  // R10
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scc_word |=> phase_o == $past(phase_o) + 1'b1);

  // R10
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scc_word |=> $stable(phase_o));

  // R13
  idle_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (sel_o == '0 && !rdata_drive_o));
endmodule

bind bus_addr_decoder bus_addr_decoder_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .addr_i        (addr_i),
  .rd_i          (rd_i),
  .word_i        (word_i),
  .sel_o         (sel_o),
  .rdata_o       (rdata_o),
  .rdata_drive_o (rdata_drive_o),
  .phase_o       (phase_o)
);

// File: tb/bus_addr_decoder_bench.sv
`timescale 1ns/1ps
module bus_addr_decoder_bench;
  localparam int RAM_WORDS = 262144;
  localparam int ROM_WORDS = 65536;
  localparam int PHASE_W   = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic        word_i = 1'b0;
  logic        overlay_we_i = 1'b0;
  logic        overlay_i = 1'b0;
  logic [7:0]  via_rdata_i = '0;
  logic [7:0]  fdc_rdata_i = '0;
  logic [7:0]  scc_rdata_i = '0;
  logic [6:0]  sel_o;
  logic [3:0]  reg_idx_o;
  logic [17:0] ram_off_o;
  logic [15:0] rom_off_o;
  logic [15:0] rdata_o;
  logic        rdata_drive_o;
  logic [2:0]  phase_o;

  int checks = 0;
  int failures = 0;
  int m_phase = 0;
  bit m_ov = 1'b1;

  always #2.5 clk_i = ~clk_i;

  bus_addr_decoder #(.RAM_WORDS(RAM_WORDS), .ROM_WORDS(ROM_WORDS), .PHASE_W(PHASE_W))
    u_bus_addr_decoder (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model: byte-address ranges, not segment table.
  task automatic model(input int a, input bit v, input bit rd, input bit wd,
                       output int sel, output bit drv, output int rdat, output bit stp,
                       output string req);
    string dev;
    int a0 = a & 1;
    bit unm = 0;
    sel = 0; drv = 0; rdat = 0; stp = 0;
    if (a < 'h800000) begin
      if (m_ov) begin
        req = "R1";
        if (a >= 'h600000) dev = "ram";
        else dev = ((a / 'h100000) % 2 == 0) ? "rom" : "none";
      end else begin
        req = "R2";
        dev = (a < 'h400000) ? "ram" : (a < 'h500000) ? "rom" : "none";
      end
    end else begin
      req = "R3";
      if (a >= 'h900000 && a < 'hA00000)      dev = "sccrd";
      else if (a >= 'hB00000 && a < 'hC00000) dev = "sccwr";
      else if (a >= 'hD00000 && a < 'hE00000) dev = "fdc";
      else if (a >= 'hE80000 && a < 'hF00000) dev = "via";
      else if (a >= 'hF00000 && a < 'hF80000) dev = "phase";
      else dev = "none";
    end
    if (!v) begin req = "R13"; return; end
    case (dev)
      "ram": sel = 1;
      "rom": sel = rd ? 2 : 0;
      "via": if (a0 == 0) begin sel = 4; if (rd) begin drv = 1; rdat = 'hFF00 | via_rdata_i; end end else unm = 1;
      "fdc": if (a0 == 1) begin sel = 8; if (rd) begin drv = 1; rdat = 'hFF00 | fdc_rdata_i; end end else unm = 1;
      "sccrd": if (wd) begin stp = 1; unm = 1; end
               else if (a0 == 1) begin sel = 32; unm = 1; end
               else begin sel = 16; if (rd) begin drv = 1; rdat = 'hFF00 | scc_rdata_i; end end
      "sccwr": if (wd) begin stp = 1; unm = 1; end
               else begin sel = a0 ? 64 : 0; unm = 1; end
      "phase": if (rd) begin drv = 1; rdat = 'hFF00 | (m_phase % 8); end
      default: unm = 1;
    endcase
    if (unm && rd) begin drv = 1; rdat = 'hFFFF; end
  endtask

  task automatic access(input int a, input bit v, input bit rd, input bit wd);
    int sel, rdat; bit drv, stp; string req;
    @(negedge clk_i);
    addr_i = a[23:0]; valid_i = v; rd_i = rd; word_i = wd;
    via_rdata_i = 8'($urandom); fdc_rdata_i = 8'($urandom); scc_rdata_i = 8'($urandom);
    #1;
    model(a, v, rd, wd, sel, drv, rdat, stp, req);
    check(sel_o == sel[6:0], {req, " R4 sel"}, sel_o, sel);
    check(rdata_drive_o == drv, {req, " R5 drive"}, rdata_drive_o, drv);
    check(rdata_o == rdat[15:0], {req, " R6 R7 R8 R9 rdata"}, rdata_o, rdat);
    check(reg_idx_o == 4'((a >> 9) % 16), "R12 reg_idx", reg_idx_o, (a >> 9) % 16);
    check(ram_off_o == 18'((a / 2) % RAM_WORDS), "R12 ram_off", ram_off_o, (a / 2) % RAM_WORDS);
    check(rom_off_o == 16'((a / 2) % ROM_WORDS), "R12 rom_off", rom_off_o, (a / 2) % ROM_WORDS);
    check(phase_o == 3'(m_phase), "R10 phase", phase_o, m_phase);
    @(posedge clk_i);
    if (v && stp) m_phase = (m_phase + 1) % (1 << PHASE_W);
  endtask

  task automatic set_overlay(input bit val);
    @(negedge clk_i);
    valid_i = 0; overlay_we_i = 1; overlay_i = val;
    @(posedge clk_i);
    m_ov = val;
    #1 overlay_we_i = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #7 ;
    check(sel_o == 0 && phase_o == 0 && rdata_drive_o == 0, "R10 R13 reset", {sel_o, phase_o}, 0);
    #3 rst_ni = 1'b1;
    // R11: overlay resets to 1, so the boot layout applies (ROM at zero)
    access('h000100, 1, 1, 1);
    // Sweep: both layouts, every segment, all direction/size/lane combinations
    for (int ov = 1; ov >= 0; ov--) begin
      set_overlay(ov[0]);
      for (int seg = 0; seg < 32; seg++)
        for (int k = 0; k < 8; k++)
          access((seg << 19) | ($urandom & 'h7FFFE) | (k & 1), 1, k[1], k[2]);
    end
    // R10: wrap of the phase counter with readback through phase window
    for (int i = 0; i < 11; i++) begin
      access(i[0] ? 'hB00010 : 'h900020, 1, i[1], 1);
      access('hF00000, 1, 1, 0);
    end
    // R13: idle cycles in serial windows do not step phase
    for (int i = 0; i < 4; i++) access('h900000, 0, 1, 1);
    access('hF00000, 1, 1, 1);
    // R11: reload overlay and confirm low map switches next cycle
    set_overlay(1'b1);
    access('h000000, 1, 1, 0);
    access('h600000, 1, 0, 1);
    // Random traffic
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom);
      if (i == 150) set_overlay(1'b0);
      access(r & 'hFFFFFF, (r >> 24) % 4 != 0, r[25], r[26]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule